// File: doc/BRIEF.md
# Multi-port GPIO register bank

This block is an APB slave that owns the software-visible state of up to four 32-bit general-purpose I/O ports. Every port holds a data-out word and a direction word. Those two words drive the pad output and output-enable buses directly from flops. The pad inputs pass through a multi-stage synchronizer, and software reads the result as a read-only pin word for each port.

Port A also owns the configuration for an interrupt unit that sits outside this block. That configuration is an enable word, a mask word, a trigger-type word, a polarity word and a debounce word, and each of them appears on an output bus. The external unit supplies a pending-status word, and software reads it through the bank. A write to the clear register sends a one-cycle clear strobe to that unit. A static strap input selects one of two address layouts for the interrupt registers.

The address map interleaves the ports. Data and direction words for successive ports sit three words apart. The pin-read words sit one word apart in a separate window. Transfers always complete with zero wait states and never signal an error.

Top module: `gpio_bank_apb`

## Requirements
- R1: After synchronous reset, all data, direction and interrupt configuration words are 0, so pad_oe, pad_out, every irq_* configuration output, irq_clr and prdata are 0.
- R2: For port p (0 = A up to 3 = D, p < NUM_PORTS), the data word is at byte offset 12*p and the direction word is at 12*p+4. Both read back what was last written.
- R3: Bits [32p+31:32p] of pad_out equal port p's data word, and the same bits of pad_oe equal its direction word (1 = output). Both change only on the clock edge that completes a write.
- R4: The pin word of port p reads at 0x50+4*p. It returns pad_in after the SYNC_STAGES synchronizer stages (default 2), whatever the direction setting, and writes to it have no effect.
- R5: With strap_alt = 0, the interrupt registers sit at these offsets: enable 0x30, mask 0x34, type 0x38, polarity 0x3C, status 0x40, debounce 0x48, clear 0x4C. Each configuration word reads back and appears on its irq_* output.
- R6: With strap_alt = 1, mask moves to 0x44, type to 0x34, polarity to 0x38, status to 0x3C and clear to 0x40. Enable stays at 0x30 and debounce at 0x48. 0x4C becomes unmapped.
- R7: A read of the status offset returns irq_status. A write to the clear offset drives the written value on irq_clr for exactly one cycle and changes no register. The clear offset reads 0.
- R8: Bits at or above a port's line count (LINES_A..LINES_D) read as 0 and ignore writes. This applies to the port's data, direction and pin words, and for port A to its interrupt words and status. The matching pad_out and pad_oe bits stay 0.
- R9: Unmapped offsets, offsets with paddr[1:0] not 0, and registers of ports at or above NUM_PORTS read 0, and writes to them have no effect. pslverr is always 0.
- R10: pready is always 1. A write takes effect on the edge where psel, penable and pwrite are all 1. Read data is captured at the setup edge, is valid throughout the access phase, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data (registered) |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| strap_alt | input | 1 | Selects the alternate interrupt register layout |
| pad_in | input | 32*NUM_PORTS | Asynchronous pad inputs, port p in bits [32p+31:32p] |
| pad_out | output | 32*NUM_PORTS | Pad output values |
| pad_oe | output | 32*NUM_PORTS | Pad output enables |
| irq_en | output | 32 | Interrupt enable word |
| irq_mask | output | 32 | Interrupt mask word |
| irq_type | output | 32 | Trigger type word |
| irq_pol | output | 32 | Trigger polarity word |
| irq_deb | output | 32 | Debounce enable word |
| irq_status | input | 32 | Pending status from the interrupt unit |
| irq_clr | output | 32 | One-cycle clear strobe to the interrupt unit |

## Verification
The bench uses a three-port configuration with line counts of 24, 8 and 32. It writes a distinct value to every word address under both strap settings, and after each write it reads back the whole address space. A decoder that used a one-word stride for data and direction, swapped a pair of offsets in the alternate layout, or mapped the absent fourth port would show up as a wrong value at some other address. A missing line mask shows up as stray high bits on port B and in the port A interrupt words. A clear write that lasted more than one cycle or leaked into the mask is also caught. A pin read issued right after pad_in changes must still return the old value, so a synchronizer that is one stage short is caught.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned MAX_PORTS = 4;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ADDR_W    = 8;

  // port register pair spacing and pin-read window
  localparam int unsigned PAIR_STRIDE = 12;
  localparam int unsigned PIN_BASE    = 'h50;
  localparam int unsigned PIN_STRIDE  = 4;

  // interrupt offsets that do not move with the strap
  localparam logic [ADDR_W-1:0] OFS_IEN = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_IDEB = 8'h48;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_DATA,
    RS_DIR,
    RS_PIN,
    RS_IEN,
    RS_IMASK,
    RS_ITYPE,
    RS_IPOL,
    RS_ISTAT,
    RS_IDEB,
    RS_ICLR
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [1:0] port;
  } reg_hit_t;

  function automatic logic [WORD_W-1:0] line_mask(input int unsigned lines);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < WORD_W; b++) m[b] = (b < lines);
    return m;
  endfunction

endpackage

// File: rtl/gpio_bank_dec.sv
module gpio_bank_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              alt,
  output reg_hit_t          hit
);

  always_comb begin
    hit.sel  = RS_NONE;
    hit.port = 2'd0;
    if (addr[1:0] == 2'b00) begin
      for (int unsigned p = 0; p < MAX_PORTS; p++) begin
        if (p < NUM_PORTS) begin
          if (addr == ADDR_W'(p * PAIR_STRIDE)) begin
            hit.sel  = RS_DATA;
            hit.port = 2'(p);
          end
          if (addr == ADDR_W'(p * PAIR_STRIDE + 4)) begin
            hit.sel  = RS_DIR;
            hit.port = 2'(p);
          end
          if (addr == ADDR_W'(PIN_BASE + p * PIN_STRIDE)) begin
            hit.sel  = RS_PIN;
            hit.port = 2'(p);
          end
        end
      end
      case (addr)
        OFS_IEN:  hit.sel = RS_IEN;
        OFS_IDEB: hit.sel = RS_IDEB;
        8'h34:    hit.sel = alt ? RS_ITYPE : RS_IMASK;
        8'h38:    hit.sel = alt ? RS_IPOL  : RS_ITYPE;
        8'h3C:    hit.sel = alt ? RS_ISTAT : RS_IPOL;
        8'h40:    hit.sel = alt ? RS_ICLR  : RS_ISTAT;
        8'h44:    hit.sel = alt ? RS_IMASK : RS_NONE;
        8'h4C:    hit.sel = alt ? RS_NONE  : RS_ICLR;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic              wr_dir,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] pad_in,
  output logic [WORD_W-1:0] data_q,
  output logic [WORD_W-1:0] dir_q,
  output logic [WORD_W-1:0] pin_q
);

  localparam logic [WORD_W-1:0] LMASK = line_mask(LINES);

  logic [WORD_W-1:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata & LMASK;
      if (wr_dir)  dir_q  <= wdata & LMASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pad_in & LMASK;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_q = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/gpio_bank_irqcfg.sv
module gpio_bank_irqcfg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_en,
  input  logic              we_mask,
  input  logic              we_type,
  input  logic              we_pol,
  input  logic              we_deb,
  input  logic              we_clr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] mask_q,
  output logic [WORD_W-1:0] type_q,
  output logic [WORD_W-1:0] pol_q,
  output logic [WORD_W-1:0] deb_q,
  output logic [WORD_W-1:0] clr_q
);

  localparam logic [WORD_W-1:0] LMASK = line_mask(LINES);

  logic [WORD_W-1:0] wv;
  assign wv = wdata & LMASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
      deb_q  <= '0;
      clr_q  <= '0;
    end else begin
      if (we_en)   en_q   <= wv;
      if (we_mask) mask_q <= wv;
      if (we_type) type_q <= wv;
      if (we_pol)  pol_q  <= wv;
      if (we_deb)  deb_q  <= wv;
      clr_q <= we_clr ? wv : '0;
    end
  end

endmodule

// File: rtl/gpio_bank_apb.sv
module gpio_bank_apb
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned LINES_A     = 32,
  parameter int unsigned LINES_B     = 32,
  parameter int unsigned LINES_C     = 32,
  parameter int unsigned LINES_D     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [7:0]                paddr,
  input  logic [31:0]               pwdata,
  output logic [31:0]               prdata,
  output logic                      pready,
  output logic                      pslverr,
  input  logic                      strap_alt,
  input  logic [32*NUM_PORTS-1:0]   pad_in,
  output logic [32*NUM_PORTS-1:0]   pad_out,
  output logic [32*NUM_PORTS-1:0]   pad_oe,
  output logic [31:0]               irq_en,
  output logic [31:0]               irq_mask,
  output logic [31:0]               irq_type,
  output logic [31:0]               irq_pol,
  output logic [31:0]               irq_deb,
  input  logic [31:0]               irq_status,
  output logic [31:0]               irq_clr
);

  localparam logic [WORD_W-1:0] MASK_A = line_mask(LINES_A);

  reg_hit_t          hit;
  logic              wr_go;
  logic              rd_setup;
  logic [WORD_W-1:0] rd_val;
  logic [WORD_W-1:0] prdata_q;
  logic [WORD_W-1:0] data_arr [MAX_PORTS];
  logic [WORD_W-1:0] dir_arr  [MAX_PORTS];
  logic [WORD_W-1:0] pin_arr  [MAX_PORTS];

  assign wr_go    = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;

  gpio_bank_dec #(.NUM_PORTS(NUM_PORTS)) u_dec (
    .addr (paddr),
    .alt  (strap_alt),
    .hit  (hit)
  );

  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
    if (p < NUM_PORTS) begin : g_on
      localparam int unsigned LN = (p == 0) ? LINES_A :
                                   (p == 1) ? LINES_B :
                                   (p == 2) ? LINES_C : LINES_D;
      gpio_bank_port #(.LINES(LN), .SYNC_STAGES(SYNC_STAGES)) u_port (
        .clk     (clk),
        .rst     (rst),
        .wr_data (wr_go && hit.sel == RS_DATA && hit.port == 2'(p)),
        .wr_dir  (wr_go && hit.sel == RS_DIR  && hit.port == 2'(p)),
        .wdata   (pwdata),
        .pad_in  (pad_in[p*32 +: 32]),
        .data_q  (data_arr[p]),
        .dir_q   (dir_arr[p]),
        .pin_q   (pin_arr[p])
      );
      assign pad_out[p*32 +: 32] = data_arr[p];
      assign pad_oe[p*32 +: 32]  = dir_arr[p];
    end else begin : g_off
      assign data_arr[p] = '0;
      assign dir_arr[p]  = '0;
      assign pin_arr[p]  = '0;
    end
  end

  gpio_bank_irqcfg #(.LINES(LINES_A)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .we_en   (wr_go && hit.sel == RS_IEN),
    .we_mask (wr_go && hit.sel == RS_IMASK),
    .we_type (wr_go && hit.sel == RS_ITYPE),
    .we_pol  (wr_go && hit.sel == RS_IPOL),
    .we_deb  (wr_go && hit.sel == RS_IDEB),
    .we_clr  (wr_go && hit.sel == RS_ICLR),
    .wdata   (pwdata),
    .en_q    (irq_en),
    .mask_q  (irq_mask),
    .type_q  (irq_type),
    .pol_q   (irq_pol),
    .deb_q   (irq_deb),
    .clr_q   (irq_clr)
  );

  always_comb begin
    case (hit.sel)
      RS_DATA:  rd_val = data_arr[hit.port];
      RS_DIR:   rd_val = dir_arr[hit.port];
      RS_PIN:   rd_val = pin_arr[hit.port];
      RS_IEN:   rd_val = irq_en;
      RS_IMASK: rd_val = irq_mask;
      RS_ITYPE: rd_val = irq_type;
      RS_IPOL:  rd_val = irq_pol;
      RS_ISTAT: rd_val = irq_status & MASK_A;
      RS_IDEB:  rd_val = irq_deb;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata_q <= '0;
    else if (rd_setup) prdata_q <= rd_val;
  end

  assign prdata  = prdata_q;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    psel,
  input logic                    penable,
  input logic                    pwrite,
  input logic [31:0]             prdata,
  input logic [32*NUM_PORTS-1:0] pad_out,
  input logic [32*NUM_PORTS-1:0] pad_oe,
  input logic [31:0]             irq_en,
  input logic [31:0]             irq_clr
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_oe == '0 && pad_out == '0 && irq_en == '0 && prdata == '0));

  // R3
  pad_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable && pwrite) |=> ($stable(pad_oe) && $stable(pad_out)));

  // R7
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr != '0) |=> (irq_clr == '0));

  // R7
  clr_source_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr != '0) |-> $past(psel && penable && pwrite));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(psel && !penable && !pwrite) |=> $stable(prdata));

endmodule

bind gpio_bank_apb gpio_bank_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .prdata  (prdata),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .irq_en  (irq_en),
  .irq_clr (irq_clr)
);

// File: tb/tb_gpio_bank_apb.sv
module tb_gpio_bank_apb;

  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic          strap_alt = 1'b0;
  logic [32*NP-1:0] pad_in = '0;
  logic [32*NP-1:0] pad_out, pad_oe;
  logic [31:0]   irq_en, irq_mask, irq_type, irq_pol, irq_deb, irq_clr;
  logic [31:0]   irq_status = 32'hC3A5_5A3C;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_data [NP];
  logic [31:0] m_dir  [NP];
  logic [31:0] m_en, m_mask, m_type, m_pol, m_deb;

  always #10 clk = ~clk;

  gpio_bank_apb #(
    .NUM_PORTS(NP), .LINES_A(24), .LINES_B(8), .LINES_C(32), .LINES_D(32), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .strap_alt(strap_alt), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_en(irq_en), .irq_mask(irq_mask), .irq_type(irq_type), .irq_pol(irq_pol),
    .irq_deb(irq_deb), .irq_status(irq_status), .irq_clr(irq_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input int p);
    int ln;
    ln = (p == 0) ? 24 : (p == 1) ? 8 : 32;
    return (ln >= 32) ? 32'hFFFF_FFFF : ((32'd1 << ln) - 32'd1);
  endfunction

  // kinds: 0 none,1 data,2 dir,3 pin,4 en,5 mask,6 type,7 pol,8 status,9 debounce,10 clear
  function automatic int kind_of(input int a, input bit alt, output int port);
    port = 0;
    if (a % 4 != 0) return 0;
    if (a < 'h30) begin
      port = a / 12;
      if (port >= NP) return 0;
      if (a % 12 == 0) return 1;
      if (a % 12 == 4) return 2;
      return 0;
    end
    if (a >= 'h50 && a <= 'h5C) begin
      port = (a - 'h50) / 4;
      return (port < NP) ? 3 : 0;
    end
    if (a == 'h30) return 4;
    if (a == 'h48) return 9;
    if (!alt) begin
      if (a == 'h34) return 5;
      if (a == 'h38) return 6;
      if (a == 'h3C) return 7;
      if (a == 'h40) return 8;
      if (a == 'h4C) return 10;
    end else begin
      if (a == 'h34) return 6;
      if (a == 'h38) return 7;
      if (a == 'h3C) return 8;
      if (a == 'h40) return 10;
      if (a == 'h44) return 5;
    end
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input int a, input bit alt);
    int p, k;
    k = kind_of(a, alt, p);
    case (k)
      1: return m_data[p];
      2: return m_dir[p];
      3: return pad_in[p*32 +: 32] & lmask(p);
      4: return m_en;
      5: return m_mask;
      6: return m_type;
      7: return m_pol;
      8: return irq_status & lmask(0);
      9: return m_deb;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int k, input bit alt);
    if (k == 1 || k == 2) return "R2";
    if (k == 3) return "R4";
    if (k == 8 || k == 10) return "R7";
    if (k >= 4) return alt ? "R6" : "R5";
    return "R9";
  endfunction

  task automatic apb_write(input int a, input logic [31:0] v);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = 8'(a); pwdata = v;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input int a, output logic [31:0] v);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = 8'(a);
    @(negedge clk);
    penable = 1;
    v = prdata;
    chk(pready === 1'b1 && pslverr === 1'b0, "R10/R9 ready/err", {30'b0, pready, pslverr}, 32'h2);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin m_data[p] = 0; m_dir[p] = 0; end
    m_en = 0; m_mask = 0; m_type = 0; m_pol = 0; m_deb = 0;
  endtask

  task automatic check_outputs(input string req);
    for (int p = 0; p < NP; p++) begin
      chk(pad_out[p*32 +: 32] === m_data[p], {req, " pad_out (R3/R8)"}, pad_out[p*32 +: 32], m_data[p]);
      chk(pad_oe[p*32 +: 32] === m_dir[p], {req, " pad_oe (R3/R8)"}, pad_oe[p*32 +: 32], m_dir[p]);
    end
    chk(irq_en === m_en, {req, " irq_en"}, irq_en, m_en);
    chk(irq_mask === m_mask, {req, " irq_mask"}, irq_mask, m_mask);
    chk(irq_type === m_type, {req, " irq_type"}, irq_type, m_type);
    chk(irq_pol === m_pol, {req, " irq_pol"}, irq_pol, m_pol);
    chk(irq_deb === m_deb, {req, " irq_deb"}, irq_deb, m_deb);
  endtask

  task automatic read_all(input bit alt);
    logic [31:0] v, e;
    int p, k;
    for (int a = 0; a < 256; a += 4) begin
      apb_read(a, v);
      e = exp_read(a, alt);
      k = kind_of(a, alt, p);
      chk(v === e, tag_of(k, alt), v, e);
    end
  endtask

  task automatic run(input bit alt);
    logic [31:0] v, wv, e, old_pin;
    int p, k;
    strap_alt = alt;
    pad_in = {32'h5A5A_F00F, 32'h1234_56C9, 32'hFEDC_BA98} ^ {96{alt}};
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    // R1 reset state
    check_outputs("R1");
    chk(irq_clr === 32'h0, "R1 irq_clr", irq_clr, 32'h0);
    chk(prdata === 32'h0, "R1 prdata", prdata, 32'h0);
    read_all(alt);
    // misaligned and out-of-range addresses (R9)
    apb_read(32'h31, v);
    chk(v === 32'h0, "R9 misaligned read", v, 32'h0);
    for (int a = 0; a < 256; a += 4) begin
      wv = (32'h9E37_79B9 * (a + 1)) ^ {32{alt}} ^ 32'hFF00_0000;
      k = kind_of(a, alt, p);
      apb_write(a, wv);
      case (k)
        1: m_data[p] = wv & lmask(p);
        2: m_dir[p]  = wv & lmask(p);
        4: m_en   = wv & lmask(0);
        5: m_mask = wv & lmask(0);
        6: m_type = wv & lmask(0);
        7: m_pol  = wv & lmask(0);
        9: m_deb  = wv & lmask(0);
        default: ;
      endcase
      e = (k == 10) ? (wv & lmask(0)) : 32'h0;
      chk(irq_clr === e, "R7 clear strobe", irq_clr, e);
      check_outputs(tag_of(k, alt));
      read_all(alt);
      chk(irq_clr === 32'h0, "R7 clear strobe ended", irq_clr, 32'h0);
    end
    // R4 synchronizer latency: first read after a change sees old value
    old_pin = pad_in[31:0] & lmask(0);
    pad_in[31:0] = ~pad_in[31:0];
    apb_read('h50, v);
    chk(v === old_pin, "R4 pin sync latency", v, old_pin);
    apb_read('h50, v);
    e = pad_in[31:0] & lmask(0);
    chk(v === e, "R4 pin after sync", v, e);
    // R10 setup-only phase without access must not write
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = 8'h04; pwdata = 32'hFFFF_FFFF;
    @(negedge clk);
    psel = 0; pwrite = 0;
    @(negedge clk);
    chk(pad_oe[31:0] === m_dir[0], "R10 write needs access phase", pad_oe[31:0], m_dir[0]);
  endtask

  initial begin
    model_reset();
    run(1'b0);
    run(1'b1);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule